// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Accumulator Processor Core

This core runs a small accumulator instruction set on an 8-bit data path with a 16-bit address space. A state machine sequences every instruction as a fixed series of one-cycle steps. Each step uses at most one memory address. The registers a program can see are the program counter, the stack pointer, the accumulator and three flags: zero (Z), carry/borrow (C) and sign (S). Internal registers hold the opcode, one operand byte and a 16-bit effective address, which is assembled low byte first.

The core has one byte-wide memory port. Its read data must be valid in the same cycle as the address, and a write commits at the clock edge. A separate 8-bit port bus handles input and output. An instruction is the opcode byte followed by zero, one or two operand bytes. Sixteen-bit operands are stored low byte first.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC, SP, A, the flags and the internal registers clear and the core enters fetch. During reset no memory write, port write or port read is asserted, and the first cycle after reset reads address 0x0000.
- R2: Every instruction starts with a fetch cycle that reads the opcode at PC. PC advances by one for each opcode or operand byte that is read.
- R3: Immediate opcodes 0x10–0x17 take one data byte. The low three bits of the opcode select the operation: 0 load A (flags unchanged), 1 add, 2 add with C, 3 subtract, 4 compare (flags only), 5 AND, 6 OR, 7 XOR. The result lands one cycle after the data read.
- R4: Direct opcodes 0x20–0x27 use the same operation selection on the byte at a 16-bit address. The address follows the opcode, low byte first, and the operand is read in the fourth cycle. Store 0x28 writes A to that address in the fourth cycle.
- R5: Implied opcodes take two cycles: 0x01 INC, 0x02 DEC, 0x03 NOT, 0x04 NEG, 0x05 CLR, 0x06 shift left (C receives bit 7), 0x07 shift right (C receives bit 0). Z and S follow every result. C is the carry out of an add, the borrow of a subtract, compare or NEG, and 0 after AND, OR, XOR or CLR. INC, DEC and NOT leave C unchanged.
- R6: Jump opcodes 0x30 (always), 0x31 (Z=1), 0x32 (Z=0), 0x33 (C=1) and 0x34 (C=0) take four cycles. A taken jump loads PC with the target. A jump that is not taken continues at the byte after its 3-byte instruction.
- R7: PUSH 0x40 decrements SP and then writes A at the new SP in its third cycle. POP 0x41 reads A from SP and increments SP, in two cycles.
- R8: CALL 0x35 writes the return address high byte at SP−1 in cycle 5 and the low byte at SP−2 in cycle 6, leaves SP lowered by 2 and jumps. RET 0x36 reads the low byte at SP and the high byte at SP+1, raises SP by 2 and resumes there.
- R9: Opcode 0x42 loads SP from a 16-bit operand stored low byte first. It takes four cycles and changes no flag.
- R10: IN 0x50 and OUT 0x51 take a port byte. In the third cycle, IN asserts `io_re` and loads A from `io_rdata`, and OUT asserts `io_we` with A on `io_wdata`.
- R11: Any other opcode, 0x00 included, is a one-byte no-operation that lasts two cycles.
- R12: In any cycle, at most one of memory write, port write and port read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address for this cycle |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable, committed at the clock edge |
| mem_rdata | input | DATA_W | Memory read data for `mem_addr`, valid in the same cycle |
| io_addr | output | DATA_W | Port number |
| io_wdata | output | DATA_W | Port output data |
| io_we | output | 1 | Port write strobe |
| io_re | output | 1 | Port read strobe |
| io_rdata | input | DATA_W | Port input data, valid in the cycle of `io_re` |

## Verification
The properties assume that memory answers combinationally within the cycle, that the port input is stable while `io_re` is high, and that reset is held for at least one edge. The stimulus is a fixed program held in a 4 KiB image. Its stack sits well above the code, and the port input is a fixed function of the port number, so every read returns a defined byte. The program uses every opcode group, takes and skips conditional jumps, and runs nested calls. Undefined opcodes are placed in the instruction stream to show that they act as no-operations.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DEC, ST_ADRH, ST_EXEC, ST_OPER,
    ST_PUSHW, ST_RETH, ST_CALLH, ST_CALLL
  } state_e;

  typedef enum logic [3:0] {
    AO_PASS, AO_ADD, AO_ADC, AO_SUB, AO_AND, AO_OR, AO_XOR,
    AO_INC, AO_DEC, AO_NOT, AO_NEG, AO_CLR, AO_SLL, AO_SRL
  } alu_op_e;

  typedef enum logic [3:0] {
    K_NOP, K_IMPL, K_IMM, K_DIR, K_ST, K_JMP, K_CALL,
    K_RET, K_PUSH, K_POP, K_LDSP, K_IN, K_OUT
  } kind_e;

  typedef enum logic [2:0] {CD_ALL, CD_Z, CD_NZ, CD_C, CD_NC} cond_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e op;
    logic    wr_a;
    logic    set_c;
    logic    set_zs;
    cond_e   cond;
  } dec_t;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opc,
  output dec_t              dec
);

  always_comb begin
    dec = '{kind: K_NOP, op: AO_PASS, wr_a: 1'b0, set_c: 1'b0,
            set_zs: 1'b0, cond: CD_ALL};
    if (opc[7:4] == 4'h1 || opc[7:4] == 4'h2) begin
      if (opc[3] == 1'b0) begin
        dec.kind   = (opc[7:4] == 4'h1) ? K_IMM : K_DIR;
        dec.wr_a   = (opc[2:0] != 3'd4);
        dec.set_c  = (opc[2:0] != 3'd0);
        dec.set_zs = (opc[2:0] != 3'd0);
        case (opc[2:0])
          3'd0:    dec.op = AO_PASS;
          3'd1:    dec.op = AO_ADD;
          3'd2:    dec.op = AO_ADC;
          3'd3:    dec.op = AO_SUB;
          3'd4:    dec.op = AO_SUB;
          3'd5:    dec.op = AO_AND;
          3'd6:    dec.op = AO_OR;
          default: dec.op = AO_XOR;
        endcase
      end else if (opc == 8'h28) begin
        dec.kind = K_ST;
      end
    end else begin
      case (opc)
        8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07: begin
          dec.kind   = K_IMPL;
          dec.wr_a   = 1'b1;
          dec.set_zs = 1'b1;
          dec.set_c  = (opc[2:0] > 3'd3);
          case (opc[2:0])
            3'd1:    dec.op = AO_INC;
            3'd2:    dec.op = AO_DEC;
            3'd3:    dec.op = AO_NOT;
            3'd4:    dec.op = AO_NEG;
            3'd5:    dec.op = AO_CLR;
            3'd6:    dec.op = AO_SLL;
            default: dec.op = AO_SRL;
          endcase
        end
        8'h30: dec.kind = K_JMP;
        8'h31: begin dec.kind = K_JMP; dec.cond = CD_Z;  end
        8'h32: begin dec.kind = K_JMP; dec.cond = CD_NZ; end
        8'h33: begin dec.kind = K_JMP; dec.cond = CD_C;  end
        8'h34: begin dec.kind = K_JMP; dec.cond = CD_NC; end
        8'h35: dec.kind = K_CALL;
        8'h36: dec.kind = K_RET;
        8'h40: dec.kind = K_PUSH;
        8'h41: dec.kind = K_POP;
        8'h42: dec.kind = K_LDSP;
        8'h50: dec.kind = K_IN;
        8'h51: dec.kind = K_OUT;
        default: dec.kind = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam logic [DATA_W:0] ONE_X = (DATA_W+1)'(1);

  logic [DATA_W:0] ax, bx;
  assign ax = {1'b0, a};
  assign bx = {1'b0, b};

  always_comb begin
    res  = b;
    cout = cin;
    case (op)
      AO_ADD: {cout, res} = ax + bx;
      AO_ADC: {cout, res} = ax + bx + (DATA_W+1)'(cin);
      AO_SUB: {cout, res} = ax - bx;
      AO_AND: begin res = a & b; cout = 1'b0; end
      AO_OR:  begin res = a | b; cout = 1'b0; end
      AO_XOR: begin res = a ^ b; cout = 1'b0; end
      AO_INC: res = a + DATA_W'(1);
      AO_DEC: res = a - DATA_W'(1);
      AO_NOT: res = ~a;
      AO_NEG: {cout, res} = ({(DATA_W+1){1'b0}} - ax) & {ONE_X[0], {DATA_W{1'b1}}};
      AO_CLR: begin res = '0; cout = 1'b0; end
      AO_SLL: {cout, res} = {a, 1'b0};
      AO_SRL: {res, cout} = {1'b0, a};
      default: begin res = b; cout = cin; end
    endcase
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_we,
  output logic              io_re,
  input  logic [DATA_W-1:0] io_rdata
);
  import acc8_pkg::*;

  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO_A = ADDR_W'(2);

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q, sp_q, mar_q;
  logic [DATA_W-1:0] a_q, ir_q, t_q;
  logic              z_q, c_q, s_q;
  dec_t              dec;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, take, alu_go;

  acc8_decode #(.DATA_W(DATA_W)) u_dec (.opc(ir_q), .dec(dec));

  acc8_alu #(.DATA_W(DATA_W)) u_alu (
    .op(dec.op), .a(a_q), .b(t_q), .cin(c_q), .res(alu_res), .cout(alu_c)
  );

  always_comb begin
    case (dec.cond)
      CD_ALL:  take = 1'b1;
      CD_Z:    take = z_q;
      CD_NZ:   take = !z_q;
      CD_C:    take = c_q;
      CD_NC:   take = !c_q;
      default: take = 1'b0;
    endcase
  end

  assign alu_go = (state_q == ST_DEC && dec.kind == K_IMPL) ||
                  (state_q == ST_OPER && (dec.kind == K_IMM || dec.kind == K_DIR));

  // one address per cycle, chosen by the step
  always_comb begin
    case (state_q)
      ST_DEC:  mem_addr = (dec.kind == K_RET || dec.kind == K_POP) ? sp_q : pc_q;
      ST_EXEC: mem_addr = mar_q;
      ST_PUSHW, ST_RETH, ST_CALLH, ST_CALLL: mem_addr = sp_q;
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_we = (state_q == ST_EXEC && dec.kind == K_ST) || state_q == ST_PUSHW ||
                  state_q == ST_CALLH || state_q == ST_CALLL;
  assign mem_wdata = (state_q == ST_CALLH) ? pc_q[ADDR_W-1:DATA_W] :
                     (state_q == ST_CALLL) ? pc_q[DATA_W-1:0] : a_q;
  assign io_addr  = t_q;
  assign io_wdata = a_q;
  assign io_we    = (state_q == ST_OPER && dec.kind == K_OUT);
  assign io_re    = (state_q == ST_OPER && dec.kind == K_IN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q <= '0; sp_q <= '0; mar_q <= '0;
      a_q <= '0; ir_q <= '0; t_q <= '0;
      z_q <= 1'b0; c_q <= 1'b0; s_q <= 1'b0;
    end else begin
      if (alu_go) begin
        if (dec.wr_a) a_q <= alu_res;
        if (dec.set_c) c_q <= alu_c;
        if (dec.set_zs) begin
          z_q <= (alu_res == '0);
          s_q <= alu_res[DATA_W-1];
        end
      end
      state_q <= ST_FETCH;
      case (state_q)
        ST_FETCH: begin
          ir_q <= mem_rdata; pc_q <= pc_q + ONE_A; state_q <= ST_DEC;
        end
        ST_DEC: begin
          case (dec.kind)
            K_IMM, K_IN, K_OUT: begin
              t_q <= mem_rdata; pc_q <= pc_q + ONE_A; state_q <= ST_OPER;
            end
            K_DIR, K_ST, K_JMP, K_CALL, K_LDSP: begin
              mar_q[DATA_W-1:0] <= mem_rdata; pc_q <= pc_q + ONE_A; state_q <= ST_ADRH;
            end
            K_PUSH: begin sp_q <= sp_q - ONE_A; state_q <= ST_PUSHW; end
            K_POP:  begin a_q <= mem_rdata; sp_q <= sp_q + ONE_A; end
            K_RET: begin
              mar_q[DATA_W-1:0] <= mem_rdata; sp_q <= sp_q + ONE_A; state_q <= ST_RETH;
            end
            default: ;
          endcase
        end
        ST_ADRH: begin
          mar_q[ADDR_W-1:DATA_W] <= mem_rdata; pc_q <= pc_q + ONE_A; state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          case (dec.kind)
            K_DIR:  begin t_q <= mem_rdata; state_q <= ST_OPER; end
            K_JMP:  if (take) pc_q <= mar_q;
            K_CALL: begin sp_q <= sp_q - ONE_A; state_q <= ST_CALLH; end
            K_LDSP: sp_q <= mar_q;
            default: ;
          endcase
        end
        ST_OPER:  if (dec.kind == K_IN) a_q <= io_rdata;
        ST_RETH:  begin pc_q <= {mem_rdata, mar_q[DATA_W-1:0]}; sp_q <= sp_q + ONE_A; end
        ST_CALLH: begin sp_q <= sp_q - ONE_A; state_q <= ST_CALLL; end
        ST_CALLL: pc_q <= mar_q;
        default: ;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_q == ST_FETCH && pc_q == '0 && sp_q == '0 && a_q == '0));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + ONE_A && state_q == ST_DEC));

  // R6
  jump_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && dec.kind == K_JMP && !take) |=> (pc_q == $past(pc_q)));

  // R7
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEC && dec.kind == K_PUSH) |=> (sp_q == $past(sp_q) - ONE_A && mem_we));

  // R8
  call_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALLL) |-> (sp_q == $past(sp_q, 2) - TWO_A));

  // R12
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_we, io_we, io_re}) <= 1);

endmodule

// File: tb/acc8_core_tb.sv
`timescale 1ns/1ps
module acc8_core_tb_top;

  typedef struct packed {
    bit        care;
    bit [15:0] addr;
    bit        we;
    bit [7:0]  wd;
    bit        iow;
    bit        ior;
    bit [7:0]  ioa;
    bit [7:0]  iod;
  } cyc_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_addr, io_wdata, io_rdata;
  logic        mem_we, io_we, io_re;

  logic [7:0] ram [4096];
  int mm [4096];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int pa;

  int m_pc, m_sp, m_a, m_z, m_c, m_s;
  cyc_t  eq[$];
  string tq[$];

  always #2 clk = ~clk;

  assign mem_rdata = ram[mem_addr[11:0]];
  assign io_rdata  = io_addr ^ 8'h5A;

  acc8_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_we(io_we), .io_re(io_re), .io_rdata(io_rdata)
  );

  function automatic int iofn(int p);
    return (p ^ 'h5A) & 255;
  endfunction

  task automatic put(int b);
    ram[pa] = 8'(b); mm[pa] = b & 255; pa++;
  endtask

  task automatic put3(int op, int ad);
    put(op); put(ad & 255); put((ad >> 8) & 255);
  endtask

  task automatic cyc(bit care, int ad, bit we, int wd, bit iow, bit ior,
                     int ioa, int iod, string tg);
    cyc_t r;
    r.care = care; r.addr = 16'(ad); r.we = we; r.wd = 8'(wd);
    r.iow = iow; r.ior = ior; r.ioa = 8'(ioa); r.iod = 8'(iod);
    eq.push_back(r); tq.push_back(tg);
  endtask

  task automatic zs(int r);
    m_z = ((r & 255) == 0) ? 1 : 0;
    m_s = (r >> 7) & 1;
  endtask

  task automatic arith(int k, int d);
    int r;
    case (k)
      0: m_a = d;
      1: begin r = m_a + d; m_c = (r >> 8) & 1; m_a = r & 255; zs(m_a); end
      2: begin r = m_a + d + m_c; m_c = (r >> 8) & 1; m_a = r & 255; zs(m_a); end
      3, 4: begin
        r = m_a - d; m_c = (r < 0) ? 1 : 0; zs(r & 255);
        if (k == 3) m_a = r & 255;
      end
      5: begin m_a = m_a & d; m_c = 0; zs(m_a); end
      6: begin m_a = m_a | d; m_c = 0; zs(m_a); end
      default: begin m_a = m_a ^ d; m_c = 0; zs(m_a); end
    endcase
  endtask

  // reads a 16-bit operand (two fetch-stream cycles) and returns it
  task automatic opnd16(output int ea, input string tg);
    int lo, hi;
    cyc(1, m_pc, 0, 0, 0, 0, 0, 0, tg); lo = mm[m_pc & 'hFFF]; m_pc = (m_pc + 1) & 'hFFFF;
    cyc(1, m_pc, 0, 0, 0, 0, 0, 0, tg); hi = mm[m_pc & 'hFFF]; m_pc = (m_pc + 1) & 'hFFFF;
    ea = (hi << 8) | lo;
  endtask

  task automatic model_step();
    int op, d, ea, lo, hi, tk;
    op = mm[m_pc & 'hFFF];
    cyc(1, m_pc, 0, 0, 0, 0, 0, 0, "R2");
    m_pc = (m_pc + 1) & 'hFFFF;
    if (op >= 'h01 && op <= 'h07) begin            // R5
      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");
      case (op)
        1: begin m_a = (m_a + 1) & 255; zs(m_a); end
        2: begin m_a = (m_a + 255) & 255; zs(m_a); end
        3: begin m_a = (~m_a) & 255; zs(m_a); end
        4: begin m_c = (m_a != 0) ? 1 : 0; m_a = (256 - m_a) & 255; zs(m_a); end
        5: begin m_a = 0; m_c = 0; zs(0); end
        6: begin m_c = (m_a >> 7) & 1; m_a = (m_a << 1) & 255; zs(m_a); end
        default: begin m_c = m_a & 1; m_a = m_a >> 1; zs(m_a); end
      endcase
    end else if (op >= 'h10 && op <= 'h17) begin   // R3
      cyc(1, m_pc, 0, 0, 0, 0, 0, 0, "R3"); d = mm[m_pc & 'hFFF]; m_pc = (m_pc + 1) & 'hFFFF;
      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
      arith(op & 7, d);
    end else if (op >= 'h20 && op <= 'h27) begin   // R4
      opnd16(ea, "R4");
      cyc(1, ea, 0, 0, 0, 0, 0, 0, "R4"); d = mm[ea & 'hFFF];
      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4");
      arith(op & 7, d);
    end else begin
      case (op)
        'h28: begin opnd16(ea, "R4"); cyc(1, ea, 1, m_a, 0, 0, 0, 0, "R4"); mm[ea & 'hFFF] = m_a; end
        'h30, 'h31, 'h32, 'h33, 'h34: begin       // R6
          opnd16(ea, "R6");
          cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6");
          tk = (op == 'h30) || (op == 'h31 && m_z == 1) || (op == 'h32 && m_z == 0) ||
               (op == 'h33 && m_c == 1) || (op == 'h34 && m_c == 0);
          if (tk != 0) m_pc = ea;
        end
        'h35: begin                                 // R8
          opnd16(ea, "R8");
          cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
          cyc(1, (m_sp - 1) & 'hFFFF, 1, m_pc >> 8, 0, 0, 0, 0, "R8");
          cyc(1, (m_sp - 2) & 'hFFFF, 1, m_pc & 255, 0, 0, 0, 0, "R8");
          mm[(m_sp - 1) & 'hFFF] = m_pc >> 8; mm[(m_sp - 2) & 'hFFF] = m_pc & 255;
          m_sp = (m_sp - 2) & 'hFFFF; m_pc = ea;
        end
        'h36: begin                                 // R8
          cyc(1, m_sp, 0, 0, 0, 0, 0, 0, "R8"); lo = mm[m_sp & 'hFFF]; m_sp = (m_sp + 1) & 'hFFFF;
          cyc(1, m_sp, 0, 0, 0, 0, 0, 0, "R8"); hi = mm[m_sp & 'hFFF]; m_sp = (m_sp + 1) & 'hFFFF;
          m_pc = (hi << 8) | lo;
        end
        'h40: begin                                 // R7
          cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");
          m_sp = (m_sp - 1) & 'hFFFF;
          cyc(1, m_sp, 1, m_a, 0, 0, 0, 0, "R7"); mm[m_sp & 'hFFF] = m_a;
        end
        'h41: begin                                 // R7
          cyc(1, m_sp, 0, 0, 0, 0, 0, 0, "R7"); m_a = mm[m_sp & 'hFFF]; m_sp = (m_sp + 1) & 'hFFFF;
        end
        'h42: begin opnd16(ea, "R9"); cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9"); m_sp = ea; end
        'h50, 'h51: begin                           // R10
          cyc(1, m_pc, 0, 0, 0, 0, 0, 0, "R10"); d = mm[m_pc & 'hFFF]; m_pc = (m_pc + 1) & 'hFFFF;
          if (op == 'h50) begin cyc(0, 0, 0, 0, 0, 1, d, 0, "R10"); m_a = iofn(d); end
          else cyc(0, 0, 0, 0, 1, 0, d, m_a, "R10");
        end
        default: cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");
      endcase
    end
  endtask

  task automatic compare();
    cyc_t  e;
    string tg;
    bit    bad;
    if (eq.size() == 0) model_step();
    e = eq.pop_front(); tg = tq.pop_front();
    bad = (mem_we !== e.we) || (io_we !== e.iow) || (io_re !== e.ior) ||
          (e.care && mem_addr !== e.addr) || (e.we && mem_wdata !== e.wd) ||
          ((e.iow || e.ior) && io_addr !== e.ioa) || (e.iow && io_wdata !== e.iod);
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: addr=%h we=%b wd=%h iow=%b ior=%b ioa=%h iod=%h | exp addr=%h we=%b wd=%h iow=%b ior=%b ioa=%h iod=%h",
               tg, mem_addr, mem_we, mem_wdata, io_we, io_re, io_addr, io_wdata,
               e.addr, e.we, e.wd, e.iow, e.ior, e.ioa, e.iod);
    end
    n_chk++;
    if ($countones({mem_we, io_we, io_re}) > 1) begin  // R12
      n_bad++;
      $display("FAIL R12: we=%b io_we=%b io_re=%b exp at most one", mem_we, io_we, io_re);
    end
    if (mem_we === 1'b1) ram[mem_addr[11:0]] = mem_wdata;
  endtask

  initial begin : watchdog
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int lp;
    for (int i = 0; i < 4096; i++) begin ram[i] = 8'h00; mm[i] = 0; end
    m_pc = 0; m_sp = 0; m_a = 0; m_z = 0; m_c = 0; m_s = 0;
    ram[12'h801] = 8'hC3; mm['h801] = 'hC3;
    ram[12'h802] = 8'h3C; mm['h802] = 'h3C;
    pa = 'h000;
    put3('h42, 'h0F00);                       // R9
    put('h10); put('h7F); put('h11); put('h01); put('h51); put('h10);
    put('h11); put('h80); put3('h33, 'h0040); // JC taken
    put('h10); put('hEE);                     // skipped
    pa = 'h040;
    put('h12); put('h05); put3('h31, 'h0300); // JZ not taken
    put('h13); put('h07); put('h14); put('hFF);
    put3('h32, 'h0300); put3('h33, 'h0300); put3('h34, 'h0080);
    pa = 'h080;
    put3('h28, 'h0800);
    put('h05); put('h01); put('h02); put('h02); put('h03);
    put('h10); put('h03); put('h04); put('h06); put('h07);
    put('h15); put('h0F); put('h16); put('h30); put('h17); put('hFF);
    put('h51); put('h11);
    put3('h20, 'h0800); put3('h21, 'h0801); put3('h22, 'h0801);
    put3('h23, 'h0802); put3('h24, 'h0802); put3('h25, 'h0801);
    put3('h26, 'h0802); put3('h27, 'h0801);
    put('h51); put('h12); put('h50); put('h33); put('h51); put('h13);
    put('h40); put('h10); put('h00); put('h41); put('h51); put('h14);
    put3('h35, 'h0200); put('h51); put('h15);
    put('hFF); put('h99); put('h00);          // R11
    put('h10); put('h03);
    lp = pa; put('h02); put3('h32, lp);
    put3('h31, 'h0180);
    pa = 'h180; put3('h30, 'h0180);
    pa = 'h200;
    put('h01); put3('h35, 'h0240); put('h51); put('h20); put('h36);
    pa = 'h240;
    put('h06); put('h40); put('h41); put('h51); put('h21); put('h36);

    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;                                  // R1
    if (mem_we !== 1'b0 || io_we !== 1'b0 || io_re !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: we=%b io_we=%b io_re=%b exp 0 0 0", mem_we, io_we, io_re);
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    n_chk++;                                  // R1
    if (mem_addr !== 16'h0000) begin
      n_bad++;
      $display("FAIL R1: first address %h exp 0000", mem_addr);
    end
    compare();
    repeat (900) begin @(negedge clk); compare(); end
    n_chk++;                                  // R4 R7 R8 memory image
    begin
      int nd = 0;
      for (int i = 0; i < 4096; i++) if (ram[i] !== 8'(mm[i])) nd++;
      if (nd != 0) begin
        n_bad++;
        $display("FAIL R8: memory image differs in %0d bytes, exp 0", nd);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule